// File: doc/BRIEF.md
# Pipeline Operand Bypass Selector

This block sits in front of the ALU of a small in-order pipeline whose register instructions take three operands, the first naming the destination. An instruction that enters execute may depend on the result of the instruction just ahead of it. That result is still in the ALU result register and has not yet reached the register file. Without help, the dependent instruction would read the old register contents, for example zero, in place of the new value.

For each of the two ALU inputs, the block compares the source register number with the destination register number of the instruction one stage ahead. On a valid match it routes the previous ALU result to that input in place of the register-file read data. The selection is purely combinational. Writeback of the earlier result still goes to the register file as usual. The bypass only shortens the operand path.

A valid match needs three things: the earlier instruction writes a register, it has not been flushed, and, when register 0 is hard-wired to zero, its destination is not register 0.

Top module: `fwd_unit`

## Requirements
- R1: When a source register number differs from the previous destination number, that operand equals its register-file read data.
- R2: When the source A number equals the previous destination (4-bit numbers), write enable is 1, flush is 0 and the destination is non-zero, operand A equals the previous ALU result.
- R3: Under the same conditions for the source B number, operand B equals the previous ALU result, independently of operand A.
- R4: When both source numbers equal a valid previous destination, both operands carry the previous ALU result in the same evaluation.
- R5: With the previous write enable at 0, both operands equal their register-file read data whatever the register numbers are.
- R6: With the previous-instruction flush flag at 1, both operands equal their register-file read data whatever the register numbers are.
- R7: With register 0 hard-wired (default parameter), a previous destination of 0 never causes bypass, even when a source is also 0.
- R8: Operands follow their inputs combinationally and settle in the same cycle as the inputs, with no clock or storage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_a_idx | input | 4 | Source register number for ALU input A |
| src_b_idx | input | 4 | Source register number for ALU input B |
| prev_dst_idx | input | 4 | Destination register number of the instruction one stage ahead |
| prev_wr_en | input | 1 | Instruction one stage ahead writes its destination |
| prev_flushed | input | 1 | Instruction one stage ahead has been flushed |
| rf_a_data | input | DATA_W | Register-file read data for source A |
| rf_b_data | input | DATA_W | Register-file read data for source B |
| alu_prev_result | input | DATA_W | ALU result register holding the previous instruction's result |
| opnd_a | output | DATA_W | Selected ALU input A |
| opnd_b | output | DATA_W | Selected ALU input B |

## Verification
There is no register between the inputs and the operands, so each result is due within the cycle in which its stimulus is applied. The bench drives a new input set on the rising clock edge. It compares both operands at the next falling edge, half a period later, so that every comparison sees settled combinational values. No check waits for a later edge, which also exercises R8.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
  localparam int REG_AW = 4;
  typedef logic [REG_AW-1:0] reg_idx_t;
  typedef enum logic {SEL_RF = 1'b0, SEL_ALU = 1'b1} opnd_sel_e;
endpackage

// File: rtl/fwd_match.sv
module fwd_match
  import fwd_pkg::*;
#(
  parameter bit ZERO_REG_HARDWIRED = 1'b1
) (
  input  reg_idx_t  src_idx,
  input  reg_idx_t  dst_idx,
  input  logic      wr_en,
  input  logic      flushed,
  output opnd_sel_e sel
);
  logic dst_live;
  logic idx_eq;

  always_comb begin
    if (ZERO_REG_HARDWIRED) begin
      dst_live = wr_en && !flushed && (dst_idx != '0);
    end else begin
      dst_live = wr_en && !flushed;
    end
    idx_eq = (src_idx == dst_idx);
    sel    = (dst_live && idx_eq) ? SEL_ALU : SEL_RF;
  end
endmodule

// File: rtl/fwd_mux.sv
module fwd_mux
  import fwd_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  opnd_sel_e         sel,
  input  logic [DATA_W-1:0] rf_data,
  input  logic [DATA_W-1:0] alu_data,
  output logic [DATA_W-1:0] data_out
);
  always_comb begin
    unique case (sel)
      SEL_ALU: data_out = alu_data;
      default: data_out = rf_data;
    endcase
  end
endmodule

// File: rtl/fwd_unit.sv
module fwd_unit
  import fwd_pkg::*;
#(
  parameter int DATA_W             = 32,
  parameter bit ZERO_REG_HARDWIRED = 1'b1
) (
  input  logic [3:0]        src_a_idx,
  input  logic [3:0]        src_b_idx,
  input  logic [3:0]        prev_dst_idx,
  input  logic              prev_wr_en,
  input  logic              prev_flushed,
  input  logic [DATA_W-1:0] rf_a_data,
  input  logic [DATA_W-1:0] rf_b_data,
  input  logic [DATA_W-1:0] alu_prev_result,
  output logic [DATA_W-1:0] opnd_a,
  output logic [DATA_W-1:0] opnd_b
);
  localparam int NUM_SRC = 2;

  reg_idx_t          src_idx  [NUM_SRC];
  logic [DATA_W-1:0] rf_data  [NUM_SRC];
  logic [DATA_W-1:0] opnd     [NUM_SRC];
  opnd_sel_e         opnd_sel [NUM_SRC];

  assign src_idx[0] = src_a_idx;
  assign src_idx[1] = src_b_idx;
  assign rf_data[0] = rf_a_data;
  assign rf_data[1] = rf_b_data;
  assign opnd_a     = opnd[0];
  assign opnd_b     = opnd[1];

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_port
    fwd_match #(
      .ZERO_REG_HARDWIRED(ZERO_REG_HARDWIRED)
    ) u_match (
      .src_idx (src_idx[g]),
      .dst_idx (prev_dst_idx),
      .wr_en   (prev_wr_en),
      .flushed (prev_flushed),
      .sel     (opnd_sel[g])
    );

    fwd_mux #(
      .DATA_W(DATA_W)
    ) u_mux (
      .sel      (opnd_sel[g]),
      .rf_data  (rf_data[g]),
      .alu_data (alu_prev_result),
      .data_out (opnd[g])
    );

    // Checks relate the top inputs to the operand leaving the mux.
    always_comb begin
      if (src_idx[g] != prev_dst_idx) begin
        AST_MISMATCH_PASSES: assert (opnd[g] == rf_data[g]); // R1
      end
      if (prev_wr_en && !prev_flushed && (prev_dst_idx != '0) &&
          (src_idx[g] == prev_dst_idx)) begin
        AST_MATCH_BYPASSES: assert (opnd[g] == alu_prev_result); // R2
      end
      if (!prev_wr_en) begin
        AST_NO_WE_NO_BYPASS: assert (opnd[g] == rf_data[g]); // R5
      end
      if (prev_flushed) begin
        AST_FLUSH_NO_BYPASS: assert (opnd[g] == rf_data[g]); // R6
      end
      if (ZERO_REG_HARDWIRED && (prev_dst_idx == '0)) begin
        AST_ZERO_DST_NO_BYPASS: assert (opnd[g] == rf_data[g]); // R7
      end
    end
  end
endmodule

// File: tb/fwd_unit_test.sv
module fwd_unit_test;
  localparam int DATA_W = 32;

  logic              clk;
  logic [3:0]        src_a_idx, src_b_idx, prev_dst_idx;
  logic              prev_wr_en, prev_flushed;
  logic [DATA_W-1:0] rf_a_data, rf_b_data, alu_prev_result;
  logic [DATA_W-1:0] opnd_a, opnd_b;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  fwd_unit #(.DATA_W(DATA_W)) uut (
    .src_a_idx(src_a_idx), .src_b_idx(src_b_idx), .prev_dst_idx(prev_dst_idx),
    .prev_wr_en(prev_wr_en), .prev_flushed(prev_flushed),
    .rf_a_data(rf_a_data), .rf_b_data(rf_b_data),
    .alu_prev_result(alu_prev_result), .opnd_a(opnd_a), .opnd_b(opnd_b)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [DATA_W-1:0] exp_opnd(
      input logic [3:0] s, input logic [3:0] d, input logic we, input logic fl,
      input logic [DATA_W-1:0] rf, input logic [DATA_W-1:0] alu);
    if (we && !fl && d != 4'd0 && s == d) return alu;
    return rf;
  endfunction

  function automatic string req_of(input logic [3:0] s, input bit is_b);
    if (!prev_wr_en) return "R5";
    if (prev_flushed) return "R6";
    if (prev_dst_idx == 4'd0) return "R7";
    if (s != prev_dst_idx) return "R1";
    if (src_a_idx == prev_dst_idx && src_b_idx == prev_dst_idx) return "R4";
    return is_b ? "R3" : "R2";
  endfunction

  task automatic check_both(input string tag);
    logic [DATA_W-1:0] ea, eb;
    ea = exp_opnd(src_a_idx, prev_dst_idx, prev_wr_en, prev_flushed, rf_a_data, alu_prev_result);
    eb = exp_opnd(src_b_idx, prev_dst_idx, prev_wr_en, prev_flushed, rf_b_data, alu_prev_result);
    n_checks++;
    if (opnd_a !== ea) begin
      n_fail++;
      $display("FAIL %s/%s opnd_a actual=%h expected=%h", tag, req_of(src_a_idx, 0), opnd_a, ea);
    end
    n_checks++;
    if (opnd_b !== eb) begin
      n_fail++;
      $display("FAIL %s/%s opnd_b actual=%h expected=%h", tag, req_of(src_b_idx, 1), opnd_b, eb);
    end
  endtask

  task automatic apply(input logic [3:0] sa, input logic [3:0] sb, input logic [3:0] d,
                       input logic we, input logic fl, input string tag);
    @(posedge clk);
    src_a_idx = sa; src_b_idx = sb; prev_dst_idx = d;
    prev_wr_en = we; prev_flushed = fl;
    rf_a_data = $urandom; rf_b_data = $urandom; alu_prev_result = $urandom;
    @(negedge clk);  // R8: same-cycle result, no waiting for a later edge
    check_both(tag);
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      n_fail++; n_checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    int unused;
    unused = $urandom(32'd1234);
    src_a_idx = '0; src_b_idx = '0; prev_dst_idx = '0;
    prev_wr_en = 1'b0; prev_flushed = 1'b0;
    rf_a_data = '0; rf_b_data = '0; alu_prev_result = 32'hDEAD_BEEF;
    @(negedge clk);
    check_both("R5 idle");
    apply(4'd1, 4'd2, 4'd3, 1'b1, 1'b0, "R1 no match");
    apply(4'd3, 4'd2, 4'd3, 1'b1, 1'b0, "R2 A match");
    apply(4'd1, 4'd3, 4'd3, 1'b1, 1'b0, "R3 B match");
    apply(4'd7, 4'd7, 4'd7, 1'b1, 1'b0, "R4 both match");
    apply(4'd7, 4'd7, 4'd7, 1'b0, 1'b0, "R5 no write");
    apply(4'd7, 4'd7, 4'd7, 1'b1, 1'b1, "R6 flushed");
    apply(4'd0, 4'd0, 4'd0, 1'b1, 1'b0, "R7 zero dest");
    apply(4'd15, 4'd0, 4'd15, 1'b1, 1'b0, "R2 top register");
    for (int i = 0; i < 3000; i++) begin
      logic [3:0] d, sa, sb;
      d  = 4'($urandom_range(0, 15));
      sa = ($urandom_range(0, 1) == 0) ? d : 4'($urandom_range(0, 15));
      sb = ($urandom_range(0, 1) == 0) ? d : 4'($urandom_range(0, 15));
      apply(sa, sb, d, ($urandom_range(0, 7) != 0), ($urandom_range(0, 7) == 0), "rand");
    end
    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule